// File: doc/BRIEF.md
# Successive-Approximation ADC Sample Sequencer

This block drives a serial successive-approximation converter from the system clock. Each sample begins with a pulse on `conv_go`. The block then waits out the conversion time and a data-settle delay. It asserts chip select, waits a lead delay, and issues a fixed burst of serial clocks to shift in one result word, most significant bit first. When the last bit is in, chip select is released and the word appears on `dout` with a one-cycle `dout_vld` strobe. All timing is set by parameters counted in system-clock cycles.

The serial clock is gated by chip select and stays low at every other time, so no edge reaches the converter while it performs its bit trials. The sample period is a fixed budget. It is the sum of the conversion time, the settle delay, the lead delay, the shift time and a margin, and a new conversion never starts sooner than this. In the overlapped mode (`overlap_rd` high), the read of the previous result moves inside the conversion window. The lead delay then directly follows the start pulse. A single `trig` pulse runs one sample, and holding `free_run` high repeats samples at exactly the budgeted period.

The controller has eight states. SQ_IDLE waits for `trig` or `free_run` and goes to SQ_PULSE. SQ_PULSE drives `conv_go` for PULSE_CYC cycles. From there it goes to SQ_CONVWAIT in the normal mode, or straight to SQ_LEAD in the overlapped mode. SQ_CONVWAIT ends after CONV_CYC cycles from the pulse start and goes to SQ_SETTLE. SQ_SETTLE lasts SETTLE_CYC cycles and goes to SQ_LEAD. SQ_LEAD holds chip select low for LEAD_CYC cycles and goes to SQ_SHIFT. SQ_SHIFT runs NBITS clock periods and goes to SQ_DONE. SQ_DONE lasts one cycle, raises the strobe, and goes to SQ_HOLD. SQ_HOLD stays until the period budget has elapsed, then goes to SQ_PULSE if `free_run` is high and to SQ_IDLE if it is low.

Top module: `sar_seq_top`

## Requirements
- R1: After synchronous reset `conv_go`=0, `cs_n`=1, `sclk`=0 and `dout_vld`=0, and no conversion starts while `trig` and `free_run` stay low.
- R2: `conv_go` is high for exactly PULSE_CYC cycles per sample, and `cs_n` is high throughout that pulse.
- R3: In the normal mode, `cs_n` falls exactly CONV_CYC+SETTLE_CYC cycles after `conv_go` rises. The first `sclk` rising edge comes exactly CONV_CYC+SETTLE_CYC+LEAD_CYC+SCLK_HALF cycles after that rise.
- R4: Each sample has exactly NBITS `sclk` rising edges, spaced 2*SCLK_HALF cycles apart. `sclk` idles low, and each period is SCLK_HALF cycles low followed by SCLK_HALF cycles high.
- R5: `sclk` is low in every cycle in which `cs_n` is high.
- R6: `sdo` is sampled on each `sclk` rising edge, MSB first. The converter presents the MSB when `cs_n` falls and the next bit on each falling `sclk` edge. `dout` equals the word so presented.
- R7: `dout_vld` is high for exactly one cycle per completed sample, 2*SCLK_HALF*NBITS-SCLK_HALF cycles after the first `sclk` rise, and `cs_n` is high in that cycle.
- R8: In single-shot use a `trig` pulse while idle runs exactly one sample, and a `trig` pulse during a sample has no effect.
- R9: With `free_run` high, `conv_go` rises every FRAME_CYC = CONV_CYC+SETTLE_CYC+LEAD_CYC+2*SCLK_HALF*NBITS+MARGIN_CYC cycles. Dropping `free_run` mid-sample lets that sample finish, and no further one starts.
- R10: Two rising edges of `conv_go` are never closer than FRAME_CYC cycles.
- R11: In the overlapped mode, `cs_n` falls PULSE_CYC cycles after `conv_go` rises and `dout_vld` comes before CONV_CYC cycles have elapsed. The mode is sampled when a sample starts, so changing `overlap_rd` mid-sample has no effect on that sample.
- R12: Reset asserted mid-shift returns `conv_go`, `sclk` and `dout_vld` low and `cs_n` high at the next clock edge, and the block stays idle afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| trig | input | 1 | Starts one sample when idle |
| free_run | input | 1 | Repeat samples at the budgeted period while high |
| overlap_rd | input | 1 | 1: read previous result inside the conversion window |
| sdo | input | 1 | Serial data from the converter |
| conv_go | output | 1 | Conversion start pulse |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock, gated by chip select |
| dout | output | NBITS | Last received word |
| dout_vld | output | 1 | One-cycle strobe with a new word |

## Verification
The assertions assume that the parameters satisfy MARGIN_CYC >= 2 and PULSE_CYC < CONV_CYC. In the overlapped mode they also assume that the pulse, the lead delay and the shift fit inside CONV_CYC. Only then are the frame spacing and edge-count checks meaningful. The assertions also assume that reset is held for at least one full clock so that their history counters restart cleanly. The stimulus keeps to the default parameters and holds reset for several cycles. It changes `trig`, `free_run` and `overlap_rd` only on falling clock edges. The converter model in the bench moves `sdo` only on chip-select fall and `sclk` fall, so the data is stable at every sampling edge.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_PULSE,
        SQ_CONVWAIT,
        SQ_SETTLE,
        SQ_LEAD,
        SQ_SHIFT,
        SQ_DONE,
        SQ_HOLD
    } sq_state_t;

endpackage

// File: rtl/sar_frame_timer.sv
module sar_frame_timer #(
    parameter int FRAME_CYC = 651
) (
    input  logic clk,
    input  logic rst,
    input  logic frame_begin,
    output logic frame_ok
);
    localparam int FW = $clog2(FRAME_CYC);
    localparam logic [FW-1:0] LAST = FW'(FRAME_CYC - 1);

    logic [FW-1:0] fcnt;

    // Counts cycles since the current start pulse; saturates at the budget end.
    always_ff @(posedge clk) begin
        if (rst) begin
            fcnt <= LAST;
        end else if (frame_begin) begin
            fcnt <= '0;
        end else if (fcnt != LAST) begin
            fcnt <= fcnt + 1'b1;
        end
    end

    assign frame_ok = (fcnt == LAST);

endmodule

// File: rtl/sar_sclk_gen.sv
module sar_sclk_gen #(
    parameter int NBITS     = 16,
    parameter int SCLK_HALF = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic in_shift,
    input  logic stay_shift,
    output logic sclk_n,
    output logic rise_n,
    output logic last
);
    localparam int PW = $clog2(2 * SCLK_HALF);
    localparam int BW = $clog2(NBITS);
    localparam logic [PW-1:0] PEND = PW'(2 * SCLK_HALF - 1);
    localparam logic [PW-1:0] PHI  = PW'(SCLK_HALF);
    localparam logic [BW-1:0] BEND = BW'(NBITS - 1);

    logic [PW-1:0] pc, pc_n;
    logic [BW-1:0] bc;

    always_comb begin
        if (!in_shift || pc == PEND) begin
            pc_n = '0;
        end else begin
            pc_n = pc + 1'b1;
        end
    end

    assign sclk_n = stay_shift && (pc_n >= PHI);
    assign rise_n = stay_shift && (pc_n == PHI);
    assign last   = in_shift && (pc == PEND) && (bc == BEND);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0;
            bc <= '0;
        end else begin
            pc <= pc_n;
            if (!in_shift) begin
                bc <= '0;
            end else if (pc == PEND) begin
                bc <= bc + 1'b1;
            end
        end
    end

endmodule

// File: rtl/sar_shift_rx.sv
module sar_shift_rx #(
    parameter int NBITS = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap,
    input  logic             sdo,
    input  logic             load,
    output logic [NBITS-1:0] dout,
    output logic             dout_vld
);
    logic [NBITS-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh       <= '0;
            dout     <= '0;
            dout_vld <= 1'b0;
        end else begin
            if (cap) begin
                sh <= {sh[NBITS-2:0], sdo};
            end
            if (load) begin
                dout <= sh;
            end
            dout_vld <= load;
        end
    end

endmodule

// File: rtl/sar_seq_fsm.sv
module sar_seq_fsm
    import sar_seq_pkg::*;
#(
    parameter int PULSE_CYC  = 2,
    parameter int CONV_CYC   = 415,
    parameter int SETTLE_CYC = 5,
    parameter int LEAD_CYC   = 3
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      trig,
    input  logic      free_run,
    input  logic      overlap_rd,
    input  logic      frame_ok,
    input  logic      shift_last,
    output sq_state_t st,
    output sq_state_t st_n
);
    localparam int TW = $clog2(CONV_CYC + SETTLE_CYC + LEAD_CYC + 1);

    logic [TW-1:0] tcnt;
    logic          tmo;
    logic          mode_q;

    function automatic logic [TW-1:0] dur_of(input sq_state_t s);
        logic [TW-1:0] d;
        case (s)
            SQ_PULSE:    d = TW'(PULSE_CYC - 1);
            SQ_CONVWAIT: d = TW'(CONV_CYC - PULSE_CYC - 1);
            SQ_SETTLE:   d = TW'(SETTLE_CYC - 1);
            SQ_LEAD:     d = TW'(LEAD_CYC - 1);
            default:     d = '0;
        endcase
        return d;
    endfunction

    assign tmo = (tcnt == '0);

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            st <= SQ_IDLE;
        end else begin
            st <= st_n;
        end
    end

    // Per-state dwell timer and mode capture at sample start
    always_ff @(posedge clk) begin
        if (rst) begin
            tcnt   <= '0;
            mode_q <= 1'b0;
        end else begin
            if (st_n != st) begin
                tcnt <= dur_of(st_n);
            end else if (!tmo) begin
                tcnt <= tcnt - 1'b1;
            end
            if (st_n == SQ_PULSE && st != SQ_PULSE) begin
                mode_q <= overlap_rd;
            end
        end
    end

    // Next-state decode
    always_comb begin
        st_n = st;
        unique case (st)
            SQ_IDLE:     if ((trig || free_run) && frame_ok) st_n = SQ_PULSE;
            SQ_PULSE:    if (tmo) st_n = mode_q ? SQ_LEAD : SQ_CONVWAIT;
            SQ_CONVWAIT: if (tmo) st_n = SQ_SETTLE;
            SQ_SETTLE:   if (tmo) st_n = SQ_LEAD;
            SQ_LEAD:     if (tmo) st_n = SQ_SHIFT;
            SQ_SHIFT:    if (shift_last) st_n = SQ_DONE;
            SQ_DONE:     st_n = SQ_HOLD;
            SQ_HOLD:     if (frame_ok) st_n = free_run ? SQ_PULSE : SQ_IDLE;
            default:     st_n = SQ_IDLE;
        endcase
    end

endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top
    import sar_seq_pkg::*;
#(
    parameter int NBITS      = 16,
    parameter int SCLK_HALF  = 4,
    parameter int PULSE_CYC  = 2,
    parameter int CONV_CYC   = 415,
    parameter int SETTLE_CYC = 5,
    parameter int LEAD_CYC   = 3,
    parameter int MARGIN_CYC = 100
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig,
    input  logic             free_run,
    input  logic             overlap_rd,
    input  logic             sdo,
    output logic             conv_go,
    output logic             cs_n,
    output logic             sclk,
    output logic [NBITS-1:0] dout,
    output logic             dout_vld
);
    localparam int SHIFT_CYC = 2 * SCLK_HALF * NBITS;
    localparam int FRAME_CYC = CONV_CYC + SETTLE_CYC + LEAD_CYC + SHIFT_CYC + MARGIN_CYC;

    sq_state_t st, st_n;
    logic      frame_ok;
    logic      shift_last;
    logic      sclk_n;
    logic      rise_n;

    sar_seq_fsm #(
        .PULSE_CYC (PULSE_CYC),
        .CONV_CYC  (CONV_CYC),
        .SETTLE_CYC(SETTLE_CYC),
        .LEAD_CYC  (LEAD_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .trig      (trig),
        .free_run  (free_run),
        .overlap_rd(overlap_rd),
        .frame_ok  (frame_ok),
        .shift_last(shift_last),
        .st        (st),
        .st_n      (st_n)
    );

    sar_frame_timer #(
        .FRAME_CYC(FRAME_CYC)
    ) u_frame (
        .clk        (clk),
        .rst        (rst),
        .frame_begin(st_n == SQ_PULSE && st != SQ_PULSE),
        .frame_ok   (frame_ok)
    );

    sar_sclk_gen #(
        .NBITS    (NBITS),
        .SCLK_HALF(SCLK_HALF)
    ) u_sclk (
        .clk       (clk),
        .rst       (rst),
        .in_shift  (st == SQ_SHIFT),
        .stay_shift(st_n == SQ_SHIFT),
        .sclk_n    (sclk_n),
        .rise_n    (rise_n),
        .last      (shift_last)
    );

    sar_shift_rx #(
        .NBITS(NBITS)
    ) u_rx (
        .clk     (clk),
        .rst     (rst),
        .cap     (rise_n),
        .sdo     (sdo),
        .load    (st_n == SQ_DONE),
        .dout    (dout),
        .dout_vld(dout_vld)
    );

    // Pin outputs registered from the next state so they change on clean edges.
    always_ff @(posedge clk) begin
        if (rst) begin
            conv_go <= 1'b0;
            cs_n    <= 1'b1;
            sclk    <= 1'b0;
        end else begin
            conv_go <= (st_n == SQ_PULSE);
            cs_n    <= !(st_n == SQ_LEAD || st_n == SQ_SHIFT);
            sclk    <= sclk_n;
        end
    end

endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
    parameter int NBITS     = 16,
    parameter int FRAME_CYC = 651
) (
    input logic clk,
    input logic rst,
    input logic conv_go,
    input logic cs_n,
    input logic sclk,
    input logic dout_vld
);
    localparam int RW = $clog2(NBITS + 1) + 1;

    logic          go_d, cs_d, sclk_d, seen;
    logic [31:0]   gap;
    logic [RW-1:0] rises;

    always_ff @(posedge clk) begin
        if (rst) begin
            go_d   <= 1'b0;
            cs_d   <= 1'b1;
            sclk_d <= 1'b0;
            seen   <= 1'b0;
            gap    <= '0;
            rises  <= '0;
        end else begin
            go_d   <= conv_go;
            cs_d   <= cs_n;
            sclk_d <= sclk;
            if (conv_go && !go_d) begin
                seen <= 1'b1;
                gap  <= 32'd1;
            end else if (gap != 32'hFFFF_FFFF) begin
                gap <= gap + 1'b1;
            end
            if (!cs_n && cs_d) begin
                rises <= '0;
            end else if (sclk && !sclk_d) begin
                rises <= rises + 1'b1;
            end
        end
    end

    // R5
    a_r5_sclk_gated: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk);

    // R2
    a_r2_pulse_cs_idle: assert property (@(posedge clk) disable iff (rst)
        conv_go |-> cs_n);

    // R7
    a_r7_vld_single: assert property (@(posedge clk) disable iff (rst)
        dout_vld |=> !dout_vld);

    // R7
    a_r7_vld_cs_high: assert property (@(posedge clk) disable iff (rst)
        dout_vld |-> cs_n);

    // R10
    a_r10_frame_spacing: assert property (@(posedge clk) disable iff (rst)
        (conv_go && !go_d && seen) |-> (gap >= 32'(FRAME_CYC)));

    // R4
    a_r4_edge_count: assert property (@(posedge clk) disable iff (rst)
        (cs_n && !cs_d) |-> (rises == RW'(NBITS)));

endmodule

bind sar_seq_top sar_seq_chk #(
    .NBITS    (NBITS),
    .FRAME_CYC(FRAME_CYC)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .conv_go (conv_go),
    .cs_n    (cs_n),
    .sclk    (sclk),
    .dout_vld(dout_vld)
);

// File: tb/sim_sar_seq_top.sv
`timescale 1ns/1ps
module sim_sar_seq_top;
    localparam int NB    = 16;
    localparam int H     = 4;
    localparam int P     = 2;
    localparam int CONV  = 415;
    localparam int SET   = 5;
    localparam int LEAD  = 3;
    localparam int MARG  = 100;
    localparam int FRAME = CONV + SET + LEAD + 2 * H * NB + MARG;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          trig = 1'b0;
    logic          free_run = 1'b0;
    logic          overlap_rd = 1'b0;
    logic          sdo = 1'b0;
    logic          conv_go, cs_n, sclk, dout_vld;
    logic [NB-1:0] dout;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    sar_seq_top #(
        .NBITS(NB), .SCLK_HALF(H), .PULSE_CYC(P), .CONV_CYC(CONV),
        .SETTLE_CYC(SET), .LEAD_CYC(LEAD), .MARGIN_CYC(MARG)
    ) u0 (
        .clk(clk), .rst(rst), .trig(trig), .free_run(free_run),
        .overlap_rd(overlap_rd), .sdo(sdo), .conv_go(conv_go), .cs_n(cs_n),
        .sclk(sclk), .dout(dout), .dout_vld(dout_vld)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Converter model: MSB on chip-select fall, next bit on each sclk fall.
    logic [NB-1:0] pat = 16'hA5C3;
    logic [NB-1:0] sent = '0;
    logic [NB-1:0] adc_sh = '0;
    always @(negedge cs_n) begin
        sent   = pat;
        adc_sh = pat;
        sdo    = pat[NB-1];
        pat    = {pat[NB-2:0], pat[NB-1]} ^ 16'h1D2B;
    end
    always @(negedge sclk) begin
        if (cs_n === 1'b0) begin
            adc_sh = {adc_sh[NB-2:0], 1'b0};
            sdo    = adc_sh[NB-1];
        end
    end

    // Port monitor, sampled on the falling clock edge.
    logic p_go = 1'b0, p_cs = 1'b1, p_sclk = 1'b0, p_vld = 1'b0;
    int t_go = 0, t_csf = 0, t_first = 0, t_lrise = 0, t_vld = 0;
    int go_w = 0, period = 0, n_go = 0, n_vld = 0, n_rise = 0;
    int gap_bad = 0, sclk_bad = 0, vld_long = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (conv_go && !p_go) begin
                if (n_go > 0) period = cyc - t_go;
                t_go = cyc;
                n_go++;
                n_rise = 0;
            end
            if (!conv_go && p_go) go_w = cyc - t_go;
            if (!cs_n && p_cs) t_csf = cyc;
            if ((sclk && cs_n) || (cs_n && p_cs && sclk != p_sclk)) sclk_bad++;
            if (sclk && !p_sclk) begin
                n_rise++;
                if (n_rise == 1) t_first = cyc;
                else if (cyc - t_lrise != 2 * H) gap_bad++;
                t_lrise = cyc;
            end
            if (dout_vld) begin
                t_vld = cyc;
                n_vld++;
                chk(dout == sent, "R6 received word", int'(dout), int'(sent));
                chk(cs_n == 1'b1, "R7 cs_n high with strobe", int'(cs_n), 1);
                if (p_vld) vld_long++;
            end
        end
        p_go = conv_go; p_cs = cs_n; p_sclk = sclk; p_vld = dout_vld;
    end

    task automatic pulse_trig();
        @(negedge clk) trig = 1'b1;
        @(negedge clk) trig = 1'b0;
    endtask

    task automatic wait_vld(input string tag);
        int v0 = n_vld;
        int k = 0;
        while (n_vld == v0 && k < 3 * FRAME) begin
            @(negedge clk);
            k++;
        end
        #1;
        chk(n_vld > v0, tag, n_vld - v0, 1);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (5) @(negedge clk);
        chk(conv_go == 1'b0, "R1 conv_go at reset", int'(conv_go), 0);
        chk(cs_n == 1'b1, "R1 cs_n at reset", int'(cs_n), 1);
        chk(sclk == 1'b0, "R1 sclk at reset", int'(sclk), 0);
        chk(dout_vld == 1'b0, "R1 strobe at reset", int'(dout_vld), 0);
        rst = 1'b0;
        repeat (100) @(negedge clk);
        chk(n_go == 0, "R1 no start without request", n_go, 0);
    endtask

    task automatic t_single_timing();
        pat = 16'hA5C3;
        pulse_trig();
        wait_vld("R3 strobe arrives");
        chk(go_w == P, "R2 pulse width", go_w, P);
        chk(t_csf - t_go == CONV + SET, "R3 cs_n fall offset", t_csf - t_go, CONV + SET);
        chk(t_first - t_go == CONV + SET + LEAD + H, "R3 first sclk rise offset",
            t_first - t_go, CONV + SET + LEAD + H);
        chk(n_rise == NB, "R4 rise count", n_rise, NB);
        chk(gap_bad == 0, "R4 rise spacing", gap_bad, 0);
        chk(t_vld - t_first == 2 * H * NB - H, "R7 strobe offset",
            t_vld - t_first, 2 * H * NB - H);
    endtask

    task automatic t_single_busy();
        int g0, v0;
        repeat (FRAME) @(negedge clk);
        g0 = n_go; v0 = n_vld;
        pat = 16'hFFFF;
        pulse_trig();
        repeat (100) @(negedge clk);
        pulse_trig();
        repeat (3 * FRAME) @(negedge clk);
        chk(n_go - g0 == 1, "R8 one sample per trigger", n_go - g0, 1);
        chk(n_vld - v0 == 1, "R8 busy trigger ignored", n_vld - v0, 1);
    endtask

    task automatic t_free_run();
        int g0;
        pat = 16'h0000;
        @(negedge clk) free_run = 1'b1;
        wait_vld("R9 first free-run sample");
        wait_vld("R9 second free-run sample");
        chk(period == FRAME, "R9 period", period, FRAME);
        wait_vld("R9 third free-run sample");
        chk(period == FRAME, "R9 period again", period, FRAME);
        while (cs_n) @(negedge clk);
        free_run = 1'b0;
        g0 = n_go;
        wait_vld("R9 sample in flight completes");
        repeat (2 * FRAME) @(negedge clk);
        chk(n_go == g0, "R9 stop after drop", n_go - g0, 0);
    endtask

    task automatic t_overlap();
        int g0;
        pat = 16'h8001;
        g0 = n_go;
        @(negedge clk) overlap_rd = 1'b1;
        pulse_trig();
        while (n_go == g0) @(negedge clk);
        overlap_rd = 1'b0;
        wait_vld("R11 strobe arrives");
        chk(t_csf - t_go == P, "R11 cs_n fall offset", t_csf - t_go, P);
        chk(t_first - t_go == P + LEAD + H, "R11 first rise offset",
            t_first - t_go, P + LEAD + H);
        chk(t_vld - t_go < CONV, "R11 read inside conversion", t_vld - t_go, CONV);
        chk(n_rise == NB, "R4 rise count overlapped", n_rise, NB);
        repeat (FRAME) @(negedge clk);
    endtask

    task automatic t_reset_mid();
        int g0, v0;
        pulse_trig();
        while (n_rise < 3 || cs_n) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(cs_n == 1'b1, "R12 cs_n after reset", int'(cs_n), 1);
        chk(sclk == 1'b0, "R12 sclk after reset", int'(sclk), 0);
        chk(conv_go == 1'b0, "R12 conv_go after reset", int'(conv_go), 0);
        chk(dout_vld == 1'b0, "R12 strobe after reset", int'(dout_vld), 0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        g0 = n_go; v0 = n_vld;
        repeat (2 * FRAME) @(negedge clk);
        chk(n_go == g0 && n_vld == v0, "R12 idle after reset", n_go - g0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_single_timing();
        t_single_busy();
        t_free_run();
        t_overlap();
        t_reset_mid();
        chk(sclk_bad == 0, "R5 sclk quiet while deselected", sclk_bad, 0);
        chk(vld_long == 0, "R7 strobe one cycle", vld_long, 0);
        chk(gap_bad == 0, "R4 rise spacing overall", gap_bad, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule